// File: doc/BRIEF.md
# Bus Command Decoder for a Pattern Generator Table Memory

This block sits between a crate-style function/subaddress bus and a pattern generator. It recognises a small set of commands, answers with the command-accepted (Q) and command-recognised (X) responses, and gives the bus controller indirect access to the generator's 1K x 24 table memory. Access goes through an address register that can step forward after each access.

Reads pass through a read register. A load of the address register also starts a fetch of the word at the new address into that register. Each read command hands out the word already held in the read register, then starts the next fetch. As a result, the first two reads after an address load both return the loaded word, and later reads return the following words. The block also returns a status word and a fixed module number. It issues three one-cycle controls to the generator: stop now, stop at the next cycle start, and start at the next cycle start.

The memory array is outside the block. It is a synchronous RAM: the block presents address, write enable and read enable, and the RAM returns read data on the following clock. A command is a single-cycle `cmd_go` pulse, which stands for the strobe edge. Commands must be at least four clocks apart.

Top module: `dwc_top`

## Requirements
- R1: `x_resp` and `q_resp` are high exactly when `sub` is 0 and `fn` is one of 0, 4, 6, 9, 16, 20, 24 or 26, and low otherwise. A command with any other code or subaddress changes no state and no output: `rd_data`, the address, the read register and the controls stay as they were.
- R2: Function 20 loads the address register from `wr_data[9:0]`, with bit 9 as the most significant. Bit 15 of `wr_data` set to 1 inhibits stepping and set to 0 allows it. The new setting holds until the next load or clear.
- R3: Function 16 writes `wr_data[23:0]` to the current address. If stepping is allowed, the address then advances by one.
- R4: Function 0 copies the read register to `rd_data`, then starts a memory read at the current address into the read register. If stepping is allowed, the address then advances by one.
- R5: After a function 20 load of address A with stepping allowed, the first and second function 0 both return the word at A, and the third returns the word at A+1.
- R6: Stepping from address 0x3FF gives address 0x000.
- R7: Function 4 puts the status in `rd_data`: bit 0 is `gen_on`, bit 1 is `clk_ovf`, and all other bits are 0.
- R8: Function 6 puts the parameter `MOD_NUM` (default 70) in `rd_data`.
- R9: Function 9 pulses `gen_stop_now` for one clock. It sets the address to 0 with stepping allowed and sets the read register to 0.
- R10: Function 24 pulses `sync_off_req` and function 26 pulses `sync_on_req`, each for one clock. At most one of the three controls is high in any cycle.
- R11: `rd_data` changes only on a function 0, 4 or 6 command. It holds its value through every other command.
- R12: After reset, `rd_data` is 0, the address is 0 with stepping allowed, the read register is 0 and all controls are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_go | input | 1 | One-cycle command strobe |
| fn | input | 5 | Function code |
| sub | input | 4 | Subaddress |
| wr_data | input | 24 | Bus write lines |
| rd_data | output | 24 | Bus read lines, held between read commands |
| q_resp | output | 1 | Command accepted |
| x_resp | output | 1 | Command recognised |
| gen_on | input | 1 | Generator running flag |
| clk_ovf | input | 1 | Generator clock overflow flag |
| gen_stop_now | output | 1 | Immediate stop pulse |
| sync_off_req | output | 1 | Stop at next cycle start pulse |
| sync_on_req | output | 1 | Start at next cycle start pulse |
| mem_addr | output | 10 | Table memory address |
| mem_we | output | 1 | Table memory write enable |
| mem_wdata | output | 24 | Table memory write data |
| mem_re | output | 1 | Table memory read enable |
| mem_rdata | input | 24 | Table memory read data, one clock after `mem_re` |

## Verification
The hardest case to reach from the ports is the wrap of the address register combined with the read delay. A read at 0x3FF must fetch the top word, and the next read must return the word at 0x000. The memory contents there are known only if the bench has written them. The stimulus loads 0x3FF with stepping allowed and writes two marker words across the wrap. It then reloads 0x3FF and reads three times. Random loads are also biased towards the top of the range, and read, write and inhibit commands are mixed, so the delayed read register is checked against a bench model of the memory and the address.

// File: rtl/dwc_pkg.sv
// Package: shared operation type and command decode for the bus command decoder.
// Assumes a 5-bit function code and a 4-bit subaddress; only subaddress 0 is served.
package dwc_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_READ,
        OP_STAT,
        OP_MODID,
        OP_CLEAR,
        OP_WRITE,
        OP_LOAD,
        OP_SOFF,
        OP_SON
    } op_t;

    // Map a function/subaddress pair to the operation it selects.
    function automatic op_t decode_op(input logic [4:0] f, input logic [3:0] a);
        op_t r;
        r = OP_NONE;
        if (a == 4'd0) begin
            case (f)
                5'd0:    r = OP_READ;
                5'd4:    r = OP_STAT;
                5'd6:    r = OP_MODID;
                5'd9:    r = OP_CLEAR;
                5'd16:   r = OP_WRITE;
                5'd20:   r = OP_LOAD;
                5'd24:   r = OP_SOFF;
                5'd26:   r = OP_SON;
                default: r = OP_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/dwc_decode.sv
// Module: command decoder. Turns fn/sub into an operation code and a
// recognised flag. Purely combinational; assumes the caller qualifies with the strobe.
module dwc_decode
    import dwc_pkg::*;
(
    input  logic [4:0] fn,
    input  logic [3:0] sub,
    output op_t        op,
    output logic       known
);

    // Decode the command and flag the supported ones.
    always_comb begin
        op    = decode_op(fn, sub);
        known = (op != OP_NONE);
    end

endmodule

// File: rtl/dwc_addr_reg.sv
// Module: read/write address register with step inhibit. Load takes priority
// over step; clear takes priority over both. Assumes at most one request per cycle.
module dwc_addr_reg #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_inh,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              inhibit
);

    localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

    // Hold, load, clear or advance the address and its inhibit flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr    <= '0;
            inhibit <= 1'b0;
        end else if (load) begin
            addr    <= load_addr;
            inhibit <= load_inh;
        end else if (step && !inhibit) begin
            addr    <= addr + 1'b1;
        end
    end

    // R6: stepping from the top address lands on zero
    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !inhibit && !load && !clear && addr == ADDR_TOP) |=> (addr == '0));

    // R2: with stepping inhibited, a step request leaves the address alone
    a_r2_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step && inhibit && !load && !clear) |=> $stable(addr));

endmodule

// File: rtl/dwc_read_pipe.sv
// Module: read register. Captures memory data one clock after a read was
// issued; clear empties it. Assumes the RAM returns data exactly one clock after its read enable.
module dwc_read_pipe #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              issued,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_reg
);

    logic pending;

    // Remember that a read is in flight for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pending <= 1'b0;
        else                 pending <= issued;
    end

    // Load the read register when the memory data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) rd_reg <= '0;
        else if (pending)    rd_reg <= mem_rdata;
    end

    // R4: the read register takes the word returned by the memory
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clear) |=> (rd_reg == $past(mem_rdata)));

    // R9: a clear empties the read register
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rd_reg == '0));

endmodule

// File: rtl/dwc_top.sv
// Module: bus command decoder for the pattern generator table memory.
// Decodes commands on the cmd_go strobe, drives the external synchronous RAM,
// returns read/status/module data and pulses generator controls.
// Assumes commands at least four clocks apart so the fetch after a load or read completes.
module dwc_top
    import dwc_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 24,
    parameter int INH_BIT = 15,
    parameter int MOD_NUM = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic [4:0]        fn,
    input  logic [3:0]        sub,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              q_resp,
    output logic              x_resp,
    input  logic              gen_on,
    input  logic              clk_ovf,
    output logic              gen_stop_now,
    output logic              sync_off_req,
    output logic              sync_on_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int STAT_W = 2;

    op_t               op;
    logic              known;
    logic              go_read, go_write, go_load, go_clear;
    logic              prime;
    logic [ADDR_W-1:0] addr;
    logic              inhibit;
    logic [DATA_W-1:0] rd_reg;

    dwc_decode u_dec (
        .fn    (fn),
        .sub   (sub),
        .op    (op),
        .known (known)
    );

    // Qualify the decoded operation with the strobe.
    always_comb begin
        go_read  = cmd_go && (op == OP_READ);
        go_write = cmd_go && (op == OP_WRITE);
        go_load  = cmd_go && (op == OP_LOAD);
        go_clear = cmd_go && (op == OP_CLEAR);
        x_resp   = known;
        q_resp   = known;
    end

    dwc_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (go_clear),
        .load      (go_load),
        .load_addr (wr_data[ADDR_W-1:0]),
        .load_inh  (wr_data[INH_BIT]),
        .step      (go_read || go_write),
        .addr      (addr),
        .inhibit   (inhibit)
    );

    // Schedule the fetch of the freshly loaded address on the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n || go_clear) prime <= 1'b0;
        else                    prime <= go_load;
    end

    // Drive the external RAM from the current address.
    always_comb begin
        mem_addr  = addr;
        mem_we    = go_write;
        mem_wdata = wr_data;
        mem_re    = go_read || prime;
    end

    dwc_read_pipe #(.DATA_W(DATA_W)) u_rpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (go_clear),
        .issued    (mem_re),
        .mem_rdata (mem_rdata),
        .rd_reg    (rd_reg)
    );

    // Update the bus read lines on read-type commands only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (cmd_go) begin
            case (op)
                OP_READ:  rd_data <= rd_reg;
                OP_STAT:  rd_data <= {{(DATA_W-STAT_W){1'b0}}, clk_ovf, gen_on};
                OP_MODID: rd_data <= DATA_W'(MOD_NUM);
                default:  rd_data <= rd_data;
            endcase
        end
    end

    // Issue one-clock generator control pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_stop_now <= 1'b0;
            sync_off_req <= 1'b0;
            sync_on_req  <= 1'b0;
        end else begin
            gen_stop_now <= go_clear;
            sync_off_req <= cmd_go && (op == OP_SOFF);
            sync_on_req  <= cmd_go && (op == OP_SON);
        end
    end

    // R10: never more than one generator control at once
    a_r10_one_control: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gen_stop_now, sync_off_req, sync_on_req}));

    // R3: an allowed write advances the address by one
    a_r3_write_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !inhibit) |=> (addr == $past(addr) + 1'b1));

    // R11: rd_data holds unless a read-type command was strobed
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_go && (op == OP_READ || op == OP_STAT || op == OP_MODID)) |=> $stable(rd_data));

    // R1: an unrecognised command touches no memory
    a_r1_silent_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !x_resp) |-> !(mem_we || mem_re && !prime));

endmodule

// File: tb/sim_dwc_top.sv
module sim_dwc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_go = 1'b0;
    logic [4:0]  fn = '0;
    logic [3:0]  sub = '0;
    logic [23:0] wr_data = '0;
    logic [23:0] rd_data;
    logic        q_resp, x_resp;
    logic        gen_on = 1'b0, clk_ovf = 1'b0;
    logic        gen_stop_now, sync_off_req, sync_on_req;
    logic [9:0]  mem_addr;
    logic        mem_we, mem_re;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;

    logic [23:0] ram [1024];
    logic [23:0] mm  [1024];
    logic [9:0]  m_addr = '0;
    logic        m_inh = 1'b0;
    logic [23:0] m_rreg = '0;
    logic [23:0] m_rd = '0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    dwc_top u0 (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .fn(fn), .sub(sub),
        .wr_data(wr_data), .rd_data(rd_data), .q_resp(q_resp), .x_resp(x_resp),
        .gen_on(gen_on), .clk_ovf(clk_ovf), .gen_stop_now(gen_stop_now),
        .sync_off_req(sync_off_req), .sync_on_req(sync_on_req),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // synchronous RAM model
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    function automatic logic known(input logic [4:0] f, input logic [3:0] a);
        return (a == 0) && (f == 0 || f == 4 || f == 6 || f == 9 ||
                            f == 16 || f == 20 || f == 24 || f == 26);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one command, check responses and model the result
    task automatic op(input logic [4:0] f, input logic [3:0] a, input logic [23:0] w);
        logic k;
        k = known(f, a);
        @(negedge clk);
        fn = f; sub = a; wr_data = w; cmd_go = 1'b1;
        #1;
        chk("R1 x_resp", x_resp, k);
        chk("R1 q_resp", q_resp, k);
        @(negedge clk);
        cmd_go = 1'b0;
        chk("R9 stop pulse", gen_stop_now, k && f == 9);
        chk("R10 off pulse", sync_off_req, k && f == 24);
        chk("R10 on pulse", sync_on_req, k && f == 26);
        if (k) begin
            case (f)
                5'd0: begin
                    m_rd = m_rreg;
                    m_rreg = mm[m_addr];
                    if (!m_inh) m_addr = m_addr + 1'b1;
                end
                5'd4: m_rd = {22'd0, clk_ovf, gen_on};
                5'd6: m_rd = 24'd70;
                5'd9: begin m_addr = '0; m_inh = 1'b0; m_rreg = '0; end
                5'd16: begin
                    mm[m_addr] = w;
                    if (!m_inh) m_addr = m_addr + 1'b1;
                end
                5'd20: begin m_addr = w[9:0]; m_inh = w[15]; m_rreg = mm[w[9:0]]; end
                default: ;
            endcase
        end
        repeat (3) @(negedge clk);
        chk(f == 0 ? "R4 R5 R6 read word" : (f == 4 ? "R7 status" :
            (f == 6 ? "R8 module number" : "R11 rd_data hold")), rd_data, m_rd);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) begin
            ram[i] = 24'(i * 7919) ^ 24'h5A5A5;
            mm[i]  = ram[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 rd_data", rd_data, 0);
        chk("R12 controls", {gen_stop_now, sync_off_req, sync_on_req}, 0);
        op(5'd0, 4'd0, 24'h0);                 // R12 read register empty after reset
        // R8, R7
        op(5'd6, 4'd0, 24'h0);
        gen_on = 1'b1; clk_ovf = 1'b0; op(5'd4, 4'd0, 24'h0);
        gen_on = 1'b0; clk_ovf = 1'b1; op(5'd4, 4'd0, 24'h0);
        // R3 R6 write across the wrap, then R5 pipelined reads
        op(5'd20, 4'd0, 24'h0003FF);
        op(5'd16, 4'd0, 24'hABCDEF);
        op(5'd16, 4'd0, 24'h123456);
        op(5'd20, 4'd0, 24'h0003FF);
        op(5'd0, 4'd0, 0); op(5'd0, 4'd0, 0); op(5'd0, 4'd0, 0);
        // R2 inhibit: repeated reads and writes stay on one address
        op(5'd20, 4'd0, 24'h008010);
        op(5'd16, 4'd0, 24'h777777); op(5'd16, 4'd0, 24'h888888);
        op(5'd0, 4'd0, 0); op(5'd0, 4'd0, 0); op(5'd0, 4'd0, 0);
        // R1 R11 unrecognised commands change nothing
        op(5'd1, 4'd0, 24'h000005); op(5'd16, 4'd1, 24'hFFFFFF); op(5'd20, 4'd3, 24'h000100);
        op(5'd0, 4'd0, 0);
        // R10 sync controls, R9 clear
        op(5'd24, 4'd0, 0); op(5'd26, 4'd0, 0);
        op(5'd9, 4'd0, 0);
        op(5'd0, 4'd0, 0); op(5'd0, 4'd0, 0);
        // random mix
        for (int i = 0; i < 1500; i++) begin
            int sel;
            logic [4:0] f;
            logic [3:0] a;
            logic [23:0] w;
            sel = int'($urandom_range(0, 19));
            a = 4'd0;
            w = 24'($urandom);
            if (sel < 6)       f = 5'd0;
            else if (sel < 10) f = 5'd16;
            else if (sel < 13) begin
                f = 5'd20;
                if ($urandom_range(0, 1) == 1) w[9:0] = 10'h3FC + 10'($urandom_range(0, 3));
                w[15] = ($urandom_range(0, 5) == 0);
            end
            else if (sel == 13) f = 5'd4;
            else if (sel == 14) f = 5'd6;
            else if (sel == 15) f = 5'd24;
            else if (sel == 16) f = 5'd26;
            else if (sel == 17) f = ($urandom_range(0, 9) == 0) ? 5'd9 : 5'd0;
            else begin f = 5'($urandom); a = 4'($urandom); end
            gen_on = 1'($urandom); clk_ovf = 1'($urandom);
            op(f, a, w);
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule